// File: doc/BRIEF.md
# Command and Status Port Engine

This block is a small two-register I/O peripheral. A host selects between a command/status register and a data register with a one-bit offset. Writing the command register starts a command and sets the status flags that say what the host should do next. Reading it returns those flags. The data register takes parameter bytes while a command is waiting for them. Reads from the data register return a fill value.

Only two command codes are recognised. One is a no-op. The other is an exit request that takes a single parameter byte. When that byte arrives, the engine does one of two things depending on a configuration input. If exit is enabled, it emits a one-cycle exit request together with the byte, limited to 0x7F. If exit is disabled, it drops back to idle. Any other command code returns the engine to idle and raises a flag marking the command as unsupported. Mapping the block to a base address is left to the surrounding logic.

Top module: `cmd_port_engine`

## Requirements
- R1: After reset, a status read returns 0x04 (bit 2 idle set, all other bits clear), exit_req is low and exit_code is 0x00.
- R2: A read with sel=0 returns the status byte on rdata in the same cycle, with bits 7..4 zero. The read changes no state: status, exit_req and exit_code stay as they were.
- R3: Writing 0x00 to the command register (sel=0) sets status to 0x04. This also clears a previously set unsupported flag.
- R4: Writing 0x04 to the command register sets status to 0x02 (bit 1 awaiting-write only) and expects exactly one data byte.
- R5: Writing any other value to the command register sets status to 0x0C (idle plus bit 3 unsupported). Later data writes are then ignored.
- R6: A data write (sel=1) while status bit 1 is clear has no effect on status, exit_req or exit_code.
- R7: The data byte that completes the exit command is handled as follows when exit_en is 1 during that write. In the next cycle, exit_req is high for exactly one cycle and exit_code carries the byte. Status then reads 0x00.
- R8: If that byte is above 0x7F, exit_code is 0x7F.
- R9: If exit_en is 0 during the completing write, no exit_req is issued, exit_code keeps its old value and status returns to 0x04.
- R10: A read with sel=1 returns 0xFF. While status bit 0 is clear, the read changes no state.
- R11: Any command write abandons a pending command. For example, writing 0x00 after 0x04 gives status 0x04, and a following data write is ignored.
- R12: exit_code changes only in the cycle in which exit_req is high, and holds its value across later commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| sel | input | 1 | Register select: 0 command/status, 1 data |
| wdata | input | 8 | Write data |
| exit_en | input | 1 | Allows an exit request when the exit command completes |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| exit_req | output | 1 | One-cycle exit request |
| exit_code | output | 8 | Limited exit code, held until the next request |

## Verification
The bench builds the engine with its default parameters. These are an 8-bit offset/length counter, a 0x7F limit, the 0x00 and 0x04 opcodes and a 0xFF fill byte. With these values, every code path that a host can reach is covered. This includes exit codes on either side of the limit, both settings of exit_en, unsupported codes at 0x01 and 0xFF, and a command that is abandoned midway. The read-progress path cannot be reached through the port with these opcodes. For that path, the bench only confirms that data reads have no side effect.

// File: rtl/cmd_port_engine.sv
module cmd_port_engine #(
  parameter int         LEN_W    = 8,
  parameter logic [7:0] OP_NOOP  = 8'h00,
  parameter logic [7:0] OP_EXIT  = 8'h04,
  parameter logic [7:0] CODE_MAX = 8'h7F,
  parameter logic [7:0] FILL     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  logic       exit_en,
  output logic [7:0] rdata,
  output logic       exit_req,
  output logic [7:0] exit_code
);
  localparam int F_RD = 0;
  localparam int F_WR = 1;
  localparam logic [3:0] ST_IDLE = 4'b0100;
  localparam logic [3:0] ST_BAD  = 4'b1100;
  localparam logic [3:0] ST_WAIT = 4'b0010;

  logic [3:0]       st;
  logic             is_exit;
  logic [LEN_W-1:0] woff, wlen, roff, rlen;
  logic [7:0]       code_buf;

  wire cmd_wr  = wr_en && !sel;
  wire data_wr = wr_en && sel && st[F_WR];
  wire data_rd = rd_en && !wr_en && sel && st[F_RD];

  wire [LEN_W-1:0] woff_nx = woff + 1'b1;
  wire [LEN_W-1:0] roff_nx = roff + 1'b1;
  wire [7:0]       byte0   = (woff == '0) ? wdata : code_buf;
  wire [7:0]       clamped = (byte0 > CODE_MAX) ? CODE_MAX : byte0;

  assign rdata = sel ? FILL : {4'b0000, st};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      is_exit   <= 1'b0;
      woff      <= '0;
      wlen      <= '0;
      roff      <= '0;
      rlen      <= '0;
      code_buf  <= 8'h00;
      exit_req  <= 1'b0;
      exit_code <= 8'h00;
    end else begin
      exit_req <= 1'b0;
      if (cmd_wr) begin
        woff <= '0;
        roff <= '0;
        rlen <= '0;
        case (wdata)
          OP_NOOP: begin
            is_exit <= 1'b0;
            st      <= ST_IDLE;
            wlen    <= '0;
          end
          OP_EXIT: begin
            is_exit <= 1'b1;
            st      <= ST_WAIT;
            wlen    <= LEN_W'(1);
          end
          default: begin
            is_exit <= 1'b0;
            st      <= ST_BAD;
            wlen    <= '0;
          end
        endcase
      end else if (data_wr) begin
        if (woff == '0) code_buf <= wdata;
        woff <= woff_nx;
        if (woff_nx >= wlen) begin
          if (is_exit && exit_en) begin
            st[F_WR]  <= 1'b0;
            exit_req  <= 1'b1;
            exit_code <= clamped;
          end else begin
            st      <= ST_IDLE;
            is_exit <= 1'b0;
          end
        end
      end else if (data_rd) begin
        roff <= roff_nx;
        if (roff_nx >= rlen) begin
          st      <= ST_IDLE;
          is_exit <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_port_engine_chk.sv
module cmd_port_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       sel,
  input logic [7:0] wdata,
  input logic       exit_en,
  input logic       exit_req,
  input logic [7:0] exit_code,
  input logic [3:0] st
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !exit_req);
  // R8
  code_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> exit_code <= 8'h7F);
  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> $past(exit_en) && $past(wr_en) && $past(sel));
  // R12
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exit_req |-> $stable(exit_code));
  // R2
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !sel) |=> $stable(st) && !exit_req);
  // R6
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && !st[1]) |=> $stable(st) && !exit_req);
  // R4
  exit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel && wdata == 8'h04) |=> st == 4'b0010);
  // R5
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st[2] && st[1]));
endmodule

bind cmd_port_engine cmd_port_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
  .wdata(wdata), .exit_en(exit_en), .exit_req(exit_req),
  .exit_code(exit_code), .st(st)
);

// File: tb/cmd_port_engine_tb.sv
`timescale 1ns/1ps
module cmd_port_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0, exit_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic exit_req;
  logic [7:0] exit_code;

  int total = 0;
  int bad = 0;
  string req = "R1";

  int m_st = 4, m_cmd = 0, m_woff = 0, m_wlen = 0, m_roff = 0, m_rlen = 0;
  int m_buf = 0, m_code = 0, m_req = 0;

  always #2.5 clk = ~clk;

  cmd_port_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .exit_en(exit_en), .rdata(rdata),
    .exit_req(exit_req), .exit_code(exit_code)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input bit r, input bit s, input int d, input bit en);
    m_req = 0;
    if (w && !s) begin
      m_woff = 0; m_wlen = 0; m_roff = 0; m_rlen = 0;
      if (d == 0) begin m_cmd = 0; m_st = 4; end
      else if (d == 4) begin m_cmd = 4; m_st = 2; m_wlen = 1; end
      else begin m_cmd = 0; m_st = 12; end
    end else if (w && s) begin
      if ((m_st & 2) != 0) begin
        if (m_woff == 0) m_buf = d;
        m_woff++;
        if (m_woff >= m_wlen) begin
          if (m_cmd == 4 && en) begin
            m_st = m_st & ~2;
            m_code = (m_buf > 127) ? 127 : m_buf;
            m_req = 1;
          end else begin
            m_cmd = 0; m_st = 4;
          end
        end
      end
    end else if (r && s && (m_st & 1) != 0) begin
      m_roff++;
      if (m_roff >= m_rlen) begin m_cmd = 0; m_st = 4; end
    end
  endtask

  // one bus cycle: drive at negedge, check read data, step model, compare outputs
  task automatic op(input bit w, input bit r, input bit s, input int d, input bit en);
    wr_en = w; rd_en = r; sel = s; wdata = 8'(d); exit_en = en;
    #1;
    if (r) check({req, " rdata"}, rdata, s ? 8'hFF : m_st);
    model_step(w, r, s, d, en);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; sel = 0;
    check({req, " exit_req"}, exit_req, m_req);
    check({req, " exit_code"}, exit_code, m_code);
  endtask

  task automatic rd_status(input int exp);
    op(0, 1, 0, 0, 0);
    check({req, " status"}, m_st, exp);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1 exit_req", exit_req, 0);
    check("R1 exit_code", exit_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_status(4);

    req = "R2"; rd_status(4); rd_status(4);
    req = "R10"; op(0, 1, 1, 0, 0); rd_status(4);
    req = "R6"; op(1, 0, 1, 8'h55, 1); rd_status(4);

    req = "R5"; op(1, 0, 0, 8'h37, 1); rd_status(12);
    op(1, 0, 1, 8'h20, 1); rd_status(12);
    op(1, 0, 0, 8'hFF, 1); rd_status(12);
    req = "R3"; op(1, 0, 0, 8'h00, 1); rd_status(4);
    op(1, 0, 0, 8'h01, 1); op(1, 0, 0, 8'h00, 1); rd_status(4);

    req = "R4"; op(1, 0, 0, 8'h04, 1); rd_status(2);
    req = "R10"; op(0, 1, 1, 0, 1); rd_status(2);
    req = "R7"; op(1, 0, 1, 8'h15, 1);
    check("R7 code", exit_code, 8'h15);
    op(0, 0, 0, 0, 0);
    check("R7 single pulse", exit_req, 0);
    rd_status(0);
    req = "R6"; op(1, 0, 1, 8'h66, 1); rd_status(0);

    req = "R8"; op(1, 0, 0, 8'h04, 1); op(1, 0, 1, 8'hC8, 1);
    check("R8 clamp", exit_code, 8'h7F);
    op(1, 0, 0, 8'h04, 1); op(1, 0, 1, 8'h80, 1);
    check("R8 edge", exit_code, 8'h7F);

    req = "R9"; op(1, 0, 0, 8'h04, 0); op(1, 0, 1, 8'h33, 0);
    check("R9 no pulse", exit_req, 0);
    check("R9 code kept", exit_code, 8'h7F);
    rd_status(4);

    req = "R11"; op(1, 0, 0, 8'h04, 1); op(1, 0, 0, 8'h00, 1); rd_status(4);
    op(1, 0, 1, 8'h10, 1); rd_status(4);
    check("R11 no exit", exit_code, 8'h7F);

    req = "R12"; op(1, 0, 0, 8'h04, 1); op(1, 0, 1, 8'h7F, 1);
    op(1, 0, 0, 8'h09, 1); op(1, 0, 0, 8'h00, 1);
    check("R12 hold", exit_code, 8'h7F);
    op(1, 0, 0, 8'h04, 1); op(1, 0, 1, 8'h00, 1);
    check("R12 update", exit_code, 8'h00);
    rd_status(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule